// File: doc/BRIEF.md
# Record and Pan Button Controller

This block reads three active-low push buttons (record, left and right) and turns them into the controls a sampled-waveform viewer needs. The first is a 16-bit view address. It selects where a 64-sample display window starts in capture memory. The second is a remembered pan direction. The last two are a one-cycle start-capture pulse and a flag that selects edge-triggered capture.

The buttons are asynchronous and pass through a multi-flop synchronizer. All decisions are taken only on a one-cycle frame tick, so the buttons are read once per display frame. Between ticks the outputs do not change.

When the block is idle, left or right pans the view. Pressing record clears the view address and enters an arming phase. In that phase, left and right choose the trigger edge polarity. The capture is launched only after record has stayed released long enough.

Top module: `scope_pan_ctl`

## Requirements
- R1: After reset the view address is 0, the pan direction is 0 (down), capture_start is 0 and trig_mode is 0.
- R2: On a frame tick while idle, with only left held, the view address decreases by 1 and the pan direction becomes 0.
- R3: On a frame tick while idle, with only right held, the view address increases by 1 and the pan direction becomes 1.
- R4: On a frame tick while idle, with left and right both held, the view address moves by 64 in the remembered direction (1 = up, 0 = down) and the direction is left unchanged.
- R5: The view address never exceeds 0xFFC0. An upward step that would pass that value stops at 0xFFC0.
- R6: A downward step that would go below 0 leaves the view address at 0.
- R7: Without a frame tick, none of the outputs change and no capture starts, whatever the buttons do.
- R8: A frame tick while idle with record held sets the view address to 0 and enters arming. While arming, left and right do not move the view address.
- R9: While arming, the capture starts on the 100th consecutive frame tick on which record is seen released. A tick with record held restarts that count.
- R10: While arming, a tick with left held sets the direction to 0 and a tick with right held sets it to 1. When both are held, right wins.
- R11: capture_start is high for exactly one cycle, after the completing tick. At the same time trig_mode takes the value 1 if left or right was held on that tick, else 0, and holds it until the next completion.
- R12: A button level must be present at the pins for two clock cycles before a tick to take effect. A level that first appears in the tick's own cycle is ignored on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle evaluation strobe, once per display frame |
| rec_btn_n | input | 1 | Record button, low when pressed, asynchronous |
| left_btn_n | input | 1 | Left button, low when pressed, asynchronous |
| right_btn_n | input | 1 | Right button, low when pressed, asynchronous |
| view_addr | output | 16 | Start address of the displayed window |
| pan_dir | output | 1 | Remembered direction, 1 = up/rising edge |
| capture_start | output | 1 | One-cycle pulse launching a capture |
| trig_mode | output | 1 | 1 = per-sample edge-triggered capture |

## Verification
The checker enforces four rules on every cycle:
- the view address ceiling;
- that outputs stay quiet between frame ticks;
- the single-cycle shape of the start pulse;
- that no ticked step moves the address by more than one window, except a clear to 0.

Only the bench scenarios can show:
- the exact step sizes and directions;
- the saturation at both ends;
- the 100-release debounce and its restart;
- the selection of edge and mode during arming;
- the two-cycle synchronizer latency.

// File: rtl/scope_pan_ctl_pkg.sv
package scope_pan_ctl_pkg;
   typedef enum logic {
      ST_VIEW = 1'b0,
      ST_ARM  = 1'b1
   } arm_state_e;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
   parameter int N      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw_n,
   output logic [N-1:0] pressed
);
   localparam int CHAIN_W = N * STAGES;

   // shift chain of synchronizer stages, oldest sample in the top slice
   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[CHAIN_W-N-1:0], raw_n};
   end

   assign pressed = ~chain_q[CHAIN_W-1 -: N];
endmodule

// File: rtl/pan_step.sv
module pan_step #(
   parameter int ADDR_W    = 16,
   parameter int WIN_LEN   = 64,
   parameter int FINE_STEP = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic              clear,
   input  logic              lft,
   input  logic              rgt,
   input  logic              dir_wr,
   input  logic              dir_val,
   output logic [ADDR_W-1:0] view_addr,
   output logic              dir
);
   localparam int SUM_W = ADDR_W + 1;
   localparam logic [SUM_W-1:0] TOP_X    = SUM_W'(2**ADDR_W - WIN_LEN);
   localparam logic [SUM_W-1:0] FINE_X   = SUM_W'(FINE_STEP);
   localparam logic [SUM_W-1:0] COARSE_X = SUM_W'(WIN_LEN);

   logic [ADDR_W-1:0] addr_q, nxt_addr;
   logic              dir_q;
   logic [SUM_W-1:0]  cur_x, step_x, up_x;
   logic              both, go_up;

   always_comb begin
      both   = lft & rgt;
      go_up  = both ? dir_q : rgt;
      step_x = both ? COARSE_X : FINE_X;
      cur_x  = {1'b0, addr_q};
      up_x   = cur_x + step_x;
      if (go_up)
         nxt_addr = (up_x > TOP_X) ? TOP_X[ADDR_W-1:0] : up_x[ADDR_W-1:0];
      else
         nxt_addr = (cur_x < step_x) ? '0 : addr_q - step_x[ADDR_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       addr_q <= '0;
      else if (clear)                   addr_q <= '0;
      else if (step_en && (lft || rgt)) addr_q <= nxt_addr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      dir_q <= 1'b0;
      else if (dir_wr)                 dir_q <= dir_val;
      else if (step_en && (lft ^ rgt)) dir_q <= rgt;
   end

   assign view_addr = addr_q;
   assign dir       = dir_q;
endmodule

// File: rtl/arm_ctl.sv
module arm_ctl
   import scope_pan_ctl_pkg::*;
#(
   parameter int DEBOUNCE_EVALS = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic rec,
   input  logic lft,
   input  logic rgt,
   output logic step_en,
   output logic clr_addr,
   output logic dir_wr,
   output logic dir_val,
   output logic start,
   output logic trig
);
   localparam int CNT_W = $clog2(DEBOUNCE_EVALS + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DEBOUNCE_EVALS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

   arm_state_e       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             start_q, trig_q;

   assign step_en  = tick && (st_q == ST_VIEW) && !rec;
   assign clr_addr = tick && (st_q == ST_VIEW) && rec;
   assign dir_wr   = tick && (st_q == ST_ARM) && (lft || rgt);
   assign dir_val  = rgt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_VIEW;
         cnt_q   <= '0;
         start_q <= 1'b0;
         trig_q  <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (tick) begin
            unique case (st_q)
               ST_VIEW: if (rec) begin
                  st_q  <= ST_ARM;
                  cnt_q <= CNT_LOAD;
               end
               ST_ARM: begin
                  if (rec) begin
                     cnt_q <= CNT_LOAD;
                  end else if (cnt_q == CNT_LAST) begin
                     start_q <= 1'b1;
                     trig_q  <= lft || rgt;
                     st_q    <= ST_VIEW;
                  end else begin
                     cnt_q <= cnt_q - CNT_LAST;
                  end
               end
               default: st_q <= ST_VIEW;
            endcase
         end
      end
   end

   assign start = start_q;
   assign trig  = trig_q;
endmodule

// File: rtl/scope_pan_ctl.sv
module scope_pan_ctl #(
   parameter int ADDR_W         = 16,
   parameter int WIN_LEN        = 64,
   parameter int FINE_STEP      = 1,
   parameter int DEBOUNCE_EVALS = 100,
   parameter int SYNC_STAGES    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_tick,
   input  logic              rec_btn_n,
   input  logic              left_btn_n,
   input  logic              right_btn_n,
   output logic [ADDR_W-1:0] view_addr,
   output logic              pan_dir,
   output logic              capture_start,
   output logic              trig_mode
);
   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (WIN_LEN > 0 && WIN_LEN < 2**ADDR_W) else $error("WIN_LEN out of range");
      assert (FINE_STEP > 0 && FINE_STEP <= WIN_LEN) else $error("FINE_STEP out of range");
      assert (DEBOUNCE_EVALS >= 1) else $error("DEBOUNCE_EVALS must be positive");
   end

   logic [2:0] pressed;
   logic       step_en, clr_addr, dir_wr, dir_val;

   btn_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_n   ({rec_btn_n, left_btn_n, right_btn_n}),
      .pressed (pressed)
   );

   arm_ctl #(.DEBOUNCE_EVALS(DEBOUNCE_EVALS)) u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (frame_tick),
      .rec      (pressed[2]),
      .lft      (pressed[1]),
      .rgt      (pressed[0]),
      .step_en  (step_en),
      .clr_addr (clr_addr),
      .dir_wr   (dir_wr),
      .dir_val  (dir_val),
      .start    (capture_start),
      .trig     (trig_mode)
   );

   pan_step #(.ADDR_W(ADDR_W), .WIN_LEN(WIN_LEN), .FINE_STEP(FINE_STEP)) u_pan (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_en   (step_en),
      .clear     (clr_addr),
      .lft       (pressed[1]),
      .rgt       (pressed[0]),
      .dir_wr    (dir_wr),
      .dir_val   (dir_val),
      .view_addr (view_addr),
      .dir       (pan_dir)
   );
endmodule

// File: rtl/scope_pan_ctl_chk.sv
module scope_pan_ctl_chk #(
   parameter int ADDR_W         = 16,
   parameter int WIN_LEN        = 64,
   parameter int FINE_STEP      = 1,
   parameter int DEBOUNCE_EVALS = 100,
   parameter int SYNC_STAGES    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_tick,
   input logic [ADDR_W-1:0] view_addr,
   input logic              pan_dir,
   input logic              capture_start,
   input logic              trig_mode
);
   localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(2**ADDR_W - WIN_LEN);
   localparam logic [ADDR_W-1:0] WIN_A    = ADDR_W'(WIN_LEN);

   assert_addr_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
      view_addr <= TOP_ADDR);

   assert_quiet_between_ticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_tick) |-> ($stable(view_addr) && $stable(pan_dir)
                              && $stable(trig_mode) && !capture_start));

   assert_start_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      capture_start |=> !capture_start);

   assert_step_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(frame_tick) |-> (view_addr == '0
         || ADDR_W'(view_addr - $past(view_addr)) <= WIN_A
         || ADDR_W'($past(view_addr) - view_addr) <= WIN_A));
endmodule

bind scope_pan_ctl scope_pan_ctl_chk #(
   .ADDR_W(ADDR_W), .WIN_LEN(WIN_LEN), .FINE_STEP(FINE_STEP),
   .DEBOUNCE_EVALS(DEBOUNCE_EVALS), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/scope_pan_ctl_tb.sv
module scope_pan_ctl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int TOP_ADDR   = 16'hFFC0;
   localparam int DEB        = 100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_tick = 1'b0;
   logic        rec_btn_n = 1'b1, left_btn_n = 1'b1, right_btn_n = 1'b1;
   logic [15:0] view_addr;
   logic        pan_dir, capture_start, trig_mode;

   always #(CLK_PERIOD/2) clk = ~clk;

   scope_pan_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
      .rec_btn_n(rec_btn_n), .left_btn_n(left_btn_n), .right_btn_n(right_btn_n),
      .view_addr(view_addr), .pan_dir(pan_dir),
      .capture_start(capture_start), .trig_mode(trig_mode)
   );

   typedef struct {
      int    addr;
      logic  dir;
      logic  start;
      logic  trig;
      string tag;
   } exp_t;

   exp_t q[$];
   int   n_checks = 0, n_fail = 0;
   bit   done = 0;

   // requirement-level model state
   int   m_addr = 0, m_cnt = 0;
   logic m_dir = 0, m_trig = 0, m_arm = 0, m_start = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic model_eval(input bit rec, input bit l, input bit r);
      int step;
      bit up;
      m_start = 0;
      if (!m_arm) begin
         if (rec) begin
            m_arm = 1; m_cnt = DEB; m_addr = 0;
         end else if (l || r) begin
            step = (l && r) ? 64 : 1;
            up   = (l && r) ? m_dir : r;
            if (up) m_addr = (m_addr + step > TOP_ADDR) ? TOP_ADDR : m_addr + step;
            else    m_addr = (m_addr < step) ? 0 : m_addr - step;
            if (l != r) m_dir = r;
         end
      end else begin
         if (l || r) m_dir = r;
         if (rec) m_cnt = DEB;
         else if (m_cnt == 1) begin
            m_start = 1; m_trig = l || r; m_arm = 0;
         end else m_cnt--;
      end
   endtask

   // driver: settle buttons, pulse a tick, push the expected result
   task automatic frame(input bit rec, input bit l, input bit r, input string tag);
      exp_t e;
      rec_btn_n = ~rec; left_btn_n = ~l; right_btn_n = ~r;
      repeat (3) @(negedge clk);
      model_eval(rec, l, r);
      frame_tick = 1'b1;
      @(posedge clk);
      #1 frame_tick = 1'b0;
      e.addr = m_addr; e.dir = m_dir; e.start = m_start; e.trig = m_trig; e.tag = tag;
      q.push_back(e);
      @(negedge clk);
   endtask

   // monitor: pop and compare away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(int'(view_addr) == e.addr, e.tag, "view_addr", int'(view_addr), e.addr);
            chk(pan_dir == e.dir, e.tag, "pan_dir", int'(pan_dir), int'(e.dir));
            chk(capture_start == e.start, e.tag, "capture_start",
                int'(capture_start), int'(e.start));
            chk(trig_mode == e.trig, e.tag, "trig_mode", int'(trig_mode), int'(e.trig));
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      int a0;
      repeat (3) @(negedge clk);
      // R1 reset values
      chk(view_addr == 16'h0 && !pan_dir && !capture_start && !trig_mode,
          "R1", "reset outputs", {view_addr, pan_dir, capture_start, trig_mode}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3 / R2 fine steps, R6 lower clamp
      for (int i = 0; i < 3; i++) frame(0, 0, 1, "R3");
      frame(0, 1, 0, "R2");
      for (int i = 0; i < 4; i++) frame(0, 1, 0, "R6");
      frame(0, 1, 1, "R6");            // coarse down at 0, dir 0
      // R4 coarse steps both ways
      frame(0, 0, 1, "R3");
      frame(0, 1, 1, "R4");
      frame(0, 1, 1, "R4");
      frame(0, 1, 0, "R2");
      frame(0, 1, 1, "R4");
      frame(0, 1, 1, "R4");
      frame(0, 1, 1, "R6");

      // R5 upper clamp
      frame(0, 0, 1, "R3");
      for (int i = 0; i < 1030; i++) frame(0, 1, 1, "R5");
      frame(0, 0, 1, "R5");
      frame(0, 1, 0, "R2");
      frame(0, 0, 1, "R5");

      // R7 no tick, buttons toggling
      a0 = int'(view_addr);
      rec_btn_n = 1'b0; left_btn_n = 1'b0; right_btn_n = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         chk(int'(view_addr) == a0 && !capture_start, "R7", "hold without tick",
             int'(view_addr), a0);
      end
      rec_btn_n = 1'b1; left_btn_n = 1'b1;
      repeat (3) @(negedge clk);

      // R12 level arriving in the tick cycle is not seen
      a0 = int'(view_addr);
      left_btn_n = 1'b0; frame_tick = 1'b1;
      @(posedge clk);
      #1 frame_tick = 1'b0;
      @(negedge clk);
      chk(int'(view_addr) == a0, "R12", "late button ignored", int'(view_addr), a0);
      left_btn_n = 1'b1;
      repeat (3) @(negedge clk);

      // R8 record clears and arms; R10 direction; R9 restart
      frame(1, 0, 0, "R8");
      frame(0, 0, 1, "R10");           // right while arming: addr stays 0
      frame(0, 1, 0, "R10");
      frame(0, 1, 1, "R10");
      for (int i = 0; i < 50; i++) frame(0, 0, 0, "R9");
      frame(1, 0, 0, "R9");            // restart
      for (int i = 0; i < 99; i++) frame(0, 0, 0, "R9");
      frame(0, 0, 1, "R11");           // 100th release, right held -> triggered
      @(negedge clk);
      chk(!capture_start, "R11", "pulse width", int'(capture_start), 0);

      // second capture with no button: trig 0; then pan again
      frame(0, 0, 1, "R3");
      frame(1, 1, 0, "R8");
      for (int i = 0; i < 99; i++) frame(0, 0, 0, "R9");
      frame(0, 0, 0, "R11");
      frame(0, 0, 1, "R3");

      repeat (3) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule